// File: doc/BRIEF.md
# Internal Data Memory Address Unit

This block turns the 8-bit internal data address of a small microcontroller into a reference to physical storage. Each request carries an access mode, an address or a register index, and the two bank-select bits. The block steers the access to one of four places: the lower 128-byte RAM, the upper 128-byte RAM, the stack pointer, or an external port toward the special function registers. It holds both RAM arrays and owns the stack pointer. Single-bit accesses are carried out as a read-modify-write on the byte that holds the bit.

The unit is used by a core's execute stage. In the cycle of a request the core presents the mode and operands. Read data comes back combinationally in that same cycle. Writes, stack pointer updates and SFR write strobes take effect on the next rising clock edge. The core itself decodes instructions and holds the SFR contents. The SFR port here only carries the address, the strobes and the data.

Top module: `idm_addr_unit`

## Requirements
- R1: Reset (active-low, asynchronous) sets the stack pointer to 07H and clears both RAM arrays to 00H.
- R2: Mode codes are 0 direct, 1 indirect, 2 register, 3 bit, 4 push and 5 pop. Codes 6 and 7 perform no access. A direct or an indirect access to an address in 00H–7FH reaches the same lower RAM byte.
- R3: A direct access to an address in 80H–FFH (other than the stack pointer address) goes to the SFR port. The port carries the address, sfr_re_o on a read, sfr_we_o with the write data on a write, and sfr_rdata_i returned as read data. An indirect access to 80H–FFH reaches the upper RAM and never strobes the SFR port.
- R4: A direct access to address 81H reads or loads the stack pointer. The SFR port is not strobed.
- R5: A register access (mode 2) reaches lower RAM byte bank×8 + index. Bank is bank_i (0–3) and index is reg_idx_i (0–7).
- R6: A bit access (mode 3) with bit address below 80H uses byte 20H + addr[6:3] and bit addr[2:0] of the lower RAM. rbit_o returns that bit. A bit write changes only that bit.
- R7: A bit access with bit address 80H or above uses SFR byte {addr[7:3],000}. A bit write drives sfr_wdata_o as sfr_rdata_i with only bit addr[2:0] replaced by bit_i, and asserts both sfr_re_o and sfr_we_o.
- R8: A push increments the stack pointer and then writes wdata_i to the indirect location at the new value. This location may lie in the upper RAM, and the SFR port is never strobed.
- R9: A pop returns the indirect byte at the current stack pointer in the same cycle. It then decrements the stack pointer.
- R10: With the UPPER_EN parameter at 0, writes to the upper RAM are discarded and reads from it return 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| mode_i | input | 3 | Access mode code |
| addr_i | input | 8 | Byte address (direct/indirect) or bit address |
| reg_idx_i | input | 3 | Register index for register mode |
| bank_i | input | 2 | Bank-select bits |
| we_i | input | 1 | Write for direct, indirect, register and bit modes |
| wdata_i | input | 8 | Byte write data, push data |
| bit_i | input | 1 | Bit write value |
| rdata_o | output | 8 | Byte read data |
| rbit_o | output | 1 | Selected bit in bit mode |
| sp_o | output | 8 | Stack pointer |
| sfr_addr_o | output | 8 | SFR byte address |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data |

## Verification
The bench writes the same address 90H once in indirect mode and reads it back in direct mode. A design that ignored the mode for upper addresses would return RAM data where the SFR value belongs, or strobe the SFR port on an indirect write. Bit writes are checked against neighbouring bits and against a preloaded SFR byte. A wrong byte formula or a plain overwrite in place of a merge would corrupt other bits. Push and pop are checked across the 7FH/80H boundary and in both orders of increment and access. An off-by-one in the order would store data one byte low or read stale data. A second instance without upper RAM must show discarded writes and 00H reads.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [2:0] {
    MODE_DIR  = 3'd0,
    MODE_IND  = 3'd1,
    MODE_REG  = 3'd2,
    MODE_BIT  = 3'd3,
    MODE_PUSH = 3'd4,
    MODE_POP  = 3'd5,
    MODE_NOP6 = 3'd6,
    MODE_NOP7 = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_LOW,
    TGT_UP,
    TGT_SFR,
    TGT_SP
  } tgt_e;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_ADDR = 8'h81
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    reg_idx_i,
  input  logic [1:0]    bank_i,
  input  logic [AW-1:0] sp_i,
  output tgt_e          tgt_o,
  output logic [AW-1:0] byte_addr_o,
  output logic [2:0]    bit_sel_o
);
  logic [AW-1:0] ind_addr;

  always_comb begin
    ind_addr    = addr_i;
    tgt_o       = TGT_NONE;
    byte_addr_o = addr_i;
    bit_sel_o   = 3'd0;
    unique case (mode_i)
      MODE_DIR: begin
        if (!addr_i[AW-1])        tgt_o = TGT_LOW;
        else if (addr_i == SP_ADDR) tgt_o = TGT_SP;
        else                      tgt_o = TGT_SFR;
      end
      MODE_IND, MODE_PUSH, MODE_POP: begin
        if (mode_i == MODE_PUSH)     ind_addr = sp_i + 1'b1;
        else if (mode_i == MODE_POP) ind_addr = sp_i;
        byte_addr_o = ind_addr;
        tgt_o       = ind_addr[AW-1] ? TGT_UP : TGT_LOW;
      end
      MODE_REG: begin
        tgt_o       = TGT_LOW;
        byte_addr_o = {3'b000, bank_i, reg_idx_i};
      end
      MODE_BIT: begin
        bit_sel_o = addr_i[2:0];
        if (!addr_i[AW-1]) begin
          tgt_o       = TGT_LOW;
          byte_addr_o = {4'b0010, addr_i[6:3]};
        end else begin
          tgt_o       = TGT_SFR;
          byte_addr_o = {addr_i[7:3], 3'b000};
        end
      end
      default: tgt_o = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/idm_byte_ram.sv
module idm_byte_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/idm_stack_ptr.sv
module idm_stack_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] RESET_VAL = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          load_i,
  input  logic [AW-1:0] ldata_i,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_o <= RESET_VAL;
    else if (load_i) sp_o <= ldata_i;
    else if (inc_i)  sp_o <= sp_o + 1'b1;
    else if (dec_i)  sp_o <= sp_o - 1'b1;
  end
endmodule

// File: rtl/idm_addr_unit.sv
module idm_addr_unit
  import idm_pkg::*;
#(
  parameter bit   UPPER_EN = 1'b1,
  parameter int   AW       = 8,
  parameter logic [AW-1:0] SP_ADDR  = 8'h81,
  parameter logic [AW-1:0] SP_RESET = 8'h07,
  localparam int  HALF     = 2 ** (AW - 1),
  localparam int  HW       = AW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    reg_idx_i,
  input  logic [1:0]    bank_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  input  logic          bit_i,
  output logic [7:0]    rdata_o,
  output logic          rbit_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sfr_addr_o,
  output logic          sfr_re_o,
  output logic          sfr_we_o,
  output logic [7:0]    sfr_wdata_o,
  input  logic [7:0]    sfr_rdata_i
);
  mode_e         mode;
  tgt_e          tgt;
  logic [AW-1:0] baddr;
  logic [2:0]    bsel;
  logic [AW-1:0] sp_q;
  logic [7:0]    low_rd, up_rd, cur_byte, new_byte;
  logic          is_bit, wr;

  assign mode = mode_e'(mode_i);

  idm_decode #(.AW(AW), .SP_ADDR(SP_ADDR)) u_dec (
    .mode_i     (mode),
    .addr_i     (addr_i),
    .reg_idx_i  (reg_idx_i),
    .bank_i     (bank_i),
    .sp_i       (sp_q),
    .tgt_o      (tgt),
    .byte_addr_o(baddr),
    .bit_sel_o  (bsel)
  );

  assign is_bit = (mode == MODE_BIT);
  assign wr = req_i && (mode == MODE_PUSH ||
              (we_i && (mode == MODE_DIR || mode == MODE_IND ||
                        mode == MODE_REG || is_bit)));

  always_comb begin
    unique case (tgt)
      TGT_LOW: cur_byte = low_rd;
      TGT_UP:  cur_byte = up_rd;
      TGT_SFR: cur_byte = sfr_rdata_i;
      TGT_SP:  cur_byte = sp_q;
      default: cur_byte = '0;
    endcase
  end

  // bit writes merge into the byte just read
  always_comb begin
    new_byte = wdata_i;
    if (is_bit) begin
      new_byte       = cur_byte;
      new_byte[bsel] = bit_i;
    end
  end

  idm_byte_ram #(.DEPTH(HALF)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && tgt == TGT_LOW),
    .idx_i  (baddr[HW-1:0]),
    .wdata_i(new_byte),
    .rdata_o(low_rd)
  );

  generate
    if (UPPER_EN) begin : g_upper
      idm_byte_ram #(.DEPTH(HALF)) u_up (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr && tgt == TGT_UP),
        .idx_i  (baddr[HW-1:0]),
        .wdata_i(new_byte),
        .rdata_o(up_rd)
      );
    end else begin : g_no_upper
      assign up_rd = '0;
    end
  endgenerate

  idm_stack_ptr #(.AW(AW), .RESET_VAL(SP_RESET)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (req_i && mode == MODE_PUSH),
    .dec_i  (req_i && mode == MODE_POP),
    .load_i (wr && tgt == TGT_SP),
    .ldata_i(new_byte),
    .sp_o   (sp_q)
  );

  assign sp_o        = sp_q;
  assign rdata_o     = req_i ? cur_byte : '0;
  assign rbit_o      = req_i && is_bit && cur_byte[bsel];
  assign sfr_addr_o  = baddr;
  assign sfr_re_o    = req_i && tgt == TGT_SFR && (is_bit || !we_i);
  assign sfr_we_o    = wr && tgt == TGT_SFR;
  assign sfr_wdata_o = new_byte;
endmodule

// File: rtl/idm_checker.sv
module idm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [2:0] mode_i,
  input logic [7:0] addr_i,
  input logic [7:0] sp_o,
  input logic       sfr_re_o,
  input logic       sfr_we_o,
  input logic [7:0] sfr_addr_o,
  input logic [7:0] sfr_wdata_o,
  input logic [7:0] sfr_rdata_i
);
  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 3'd4) |=> sp_o == $past(sp_o) + 8'd1); // R8

  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 3'd5) |=> sp_o == $past(sp_o) - 8'd1); // R9

  AST_SP_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(sp_o)); // R4

  AST_SFR_WE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_we_o |-> req_i && addr_i[7] && (mode_i == 3'd0 || mode_i == 3'd3)); // R3

  AST_IND_NO_SFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (mode_i == 3'd1 || mode_i == 3'd4 || mode_i == 3'd5))
      |-> !sfr_we_o && !sfr_re_o); // R3

  AST_BIT_SFR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 3'd3 && addr_i[7])
      |-> sfr_addr_o == {addr_i[7:3], 3'b000}); // R7

  AST_BIT_RMW_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_o && mode_i == 3'd3)
      |-> $countones(sfr_wdata_o ^ sfr_rdata_i) <= 1); // R7
endmodule

bind idm_addr_unit idm_checker u_chk (.*);

// File: tb/tb_idm_addr_unit.sv
module tb_idm_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_REG = 3'd2,
                         M_BIT = 3'd3, M_PUSH = 3'd4, M_POP = 3'd5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, bit_i = 1'b0;
  logic [2:0] mode_i = '0, reg_idx_i = '0;
  logic [1:0] bank_i = '0;
  logic [7:0] addr_i = '0, wdata_i = '0, sfr_rdata_i = '0;
  logic [7:0] rdata_o, sp_o, sfr_addr_o, sfr_wdata_o;
  logic rbit_o, sfr_re_o, sfr_we_o;
  logic [7:0] rdata_nu, sp_nu, sfr_addr_nu, sfr_wdata_nu;
  logic rbit_nu, sfr_re_nu, sfr_we_nu;

  logic [7:0] c_rd, c_rd_nu, c_sfr_addr, c_sfr_wd;
  logic c_rbit, c_sfr_re, c_sfr_we;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  idm_addr_unit dut (
    .clk_i, .rst_ni, .req_i, .mode_i, .addr_i, .reg_idx_i, .bank_i, .we_i,
    .wdata_i, .bit_i, .rdata_o, .rbit_o, .sp_o, .sfr_addr_o, .sfr_re_o,
    .sfr_we_o, .sfr_wdata_o, .sfr_rdata_i
  );

  idm_addr_unit #(.UPPER_EN(1'b0)) dut_nu (
    .clk_i, .rst_ni, .req_i, .mode_i, .addr_i, .reg_idx_i, .bank_i, .we_i,
    .wdata_i, .bit_i, .rdata_o(rdata_nu), .rbit_o(rbit_nu), .sp_o(sp_nu),
    .sfr_addr_o(sfr_addr_nu), .sfr_re_o(sfr_re_nu), .sfr_we_o(sfr_we_nu),
    .sfr_wdata_o(sfr_wdata_nu), .sfr_rdata_i
  );

  task automatic chk(input bit ok, input string rq, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] m, input logic [7:0] a,
                    input logic [2:0] ix, input logic [1:0] bk,
                    input logic w, input logic [7:0] wd, input logic b);
    @(negedge clk_i);
    mode_i = m; addr_i = a; reg_idx_i = ix; bank_i = bk;
    we_i = w; wdata_i = wd; bit_i = b; req_i = 1'b1;
    #1;
    c_rd = rdata_o; c_rd_nu = rdata_nu; c_rbit = rbit_o;
    c_sfr_addr = sfr_addr_o; c_sfr_wd = sfr_wdata_o;
    c_sfr_re = sfr_re_o; c_sfr_we = sfr_we_o;
    @(posedge clk_i);
    #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(sp_o == 8'h07, "R1 sp reset", sp_o, 8'h07);
    op(M_IND, 8'h10, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h00, "R1 ram reset", c_rd, 8'h00);
  endtask

  task automatic t_lower;
    op(M_DIR, 8'h35, 0, 0, 1, 8'hA5, 0);
    op(M_IND, 8'h35, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hA5, "R2 dir->ind", c_rd, 8'hA5);
    op(M_IND, 8'h7F, 0, 0, 1, 8'h3C, 0);
    op(M_DIR, 8'h7F, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h3C, "R2 ind->dir", c_rd, 8'h3C);
  endtask

  task automatic t_split;
    op(M_IND, 8'h90, 0, 0, 1, 8'h5A, 0);
    chk(!c_sfr_we && !c_sfr_re, "R3 ind no sfr strobe", {6'b0, c_sfr_we, c_sfr_re}, 8'h00);
    sfr_rdata_i = 8'hC3;
    op(M_DIR, 8'h90, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hC3, "R3 dir read sfr data", c_rd, 8'hC3);
    chk(c_sfr_re && c_sfr_addr == 8'h90, "R3 dir read strobe/addr", c_sfr_addr, 8'h90);
    op(M_IND, 8'h90, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h5A, "R3 ind read upper", c_rd, 8'h5A);
    op(M_DIR, 8'hA0, 0, 0, 1, 8'h77, 0);
    chk(c_sfr_we && c_sfr_wd == 8'h77, "R3 dir write sfr", c_sfr_wd, 8'h77);
  endtask

  task automatic t_sp_reg;
    op(M_DIR, 8'h81, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h07 && !c_sfr_re, "R4 read sp", c_rd, 8'h07);
    op(M_DIR, 8'h81, 0, 0, 1, 8'h40, 0);
    chk(sp_o == 8'h40 && !c_sfr_we, "R4 load sp", sp_o, 8'h40);
    op(M_DIR, 8'h81, 0, 0, 1, 8'h07, 0);
  endtask

  task automatic t_bank;
    op(M_REG, 8'h00, 3'd5, 2'd2, 1, 8'h11, 0);
    op(M_IND, 8'h15, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h11, "R5 bank2 r5", c_rd, 8'h11);
    op(M_REG, 8'h00, 3'd7, 2'd3, 1, 8'h22, 0);
    op(M_IND, 8'h1F, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h22, "R5 bank3 r7", c_rd, 8'h22);
    op(M_REG, 8'h00, 3'd5, 2'd0, 0, 0, 0);
    chk(c_rd == 8'h00, "R5 bank0 r5 untouched", c_rd, 8'h00);
  endtask

  task automatic t_bit_low;
    op(M_BIT, 8'h53, 0, 0, 1, 8'hFF, 1);
    op(M_IND, 8'h2A, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h08, "R6 bit set byte 2A", c_rd, 8'h08);
    op(M_BIT, 8'h57, 0, 0, 1, 8'h00, 1);
    op(M_IND, 8'h2A, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h88, "R6 second bit keeps first", c_rd, 8'h88);
    op(M_BIT, 8'h53, 0, 0, 0, 0, 0);
    chk(c_rbit == 1'b1, "R6 bit read set", {7'b0, c_rbit}, 8'h01);
    op(M_BIT, 8'h52, 0, 0, 0, 0, 0);
    chk(c_rbit == 1'b0, "R6 bit read clear", {7'b0, c_rbit}, 8'h00);
    op(M_BIT, 8'h53, 0, 0, 1, 8'hFF, 0);
    op(M_IND, 8'h2A, 0, 0, 0, 0, 0);
    chk(c_rd == 8'h80, "R6 bit clear", c_rd, 8'h80);
  endtask

  task automatic t_bit_sfr;
    sfr_rdata_i = 8'hF0;
    op(M_BIT, 8'hD2, 0, 0, 1, 8'h00, 1);
    chk(c_sfr_addr == 8'hD0, "R7 sfr byte addr", c_sfr_addr, 8'hD0);
    chk(c_sfr_we && c_sfr_re && c_sfr_wd == 8'hF4, "R7 rmw set", c_sfr_wd, 8'hF4);
    sfr_rdata_i = 8'hFF;
    op(M_BIT, 8'hE7, 0, 0, 1, 8'h00, 0);
    chk(c_sfr_addr == 8'hE0 && c_sfr_wd == 8'h7F, "R7 rmw clear", c_sfr_wd, 8'h7F);
    sfr_rdata_i = 8'h08;
    op(M_BIT, 8'h8B, 0, 0, 0, 0, 0);
    chk(c_rbit && c_sfr_addr == 8'h88, "R7 bit read", c_sfr_addr, 8'h88);
  endtask

  task automatic t_stack;
    op(M_PUSH, 8'h00, 0, 0, 0, 8'hAA, 0);
    chk(sp_o == 8'h08, "R8 push inc", sp_o, 8'h08);
    op(M_PUSH, 8'h00, 0, 0, 0, 8'hBB, 0);
    op(M_IND, 8'h08, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hAA, "R8 push data at new sp", c_rd, 8'hAA);
    op(M_POP, 8'h00, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hBB && sp_o == 8'h08, "R9 pop top", c_rd, 8'hBB);
    op(M_POP, 8'h00, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hAA && sp_o == 8'h07, "R9 pop next", sp_o, 8'h07);
    op(M_DIR, 8'h81, 0, 0, 1, 8'h7F, 0);
    op(M_PUSH, 8'h00, 0, 0, 0, 8'hCC, 0);
    chk(!c_sfr_we && sp_o == 8'h80, "R8 push to upper", sp_o, 8'h80);
    op(M_IND, 8'h80, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hCC, "R8 upper holds push", c_rd, 8'hCC);
    chk(c_rd_nu == 8'h00, "R10 push to missing upper lost", c_rd_nu, 8'h00);
    op(M_POP, 8'h00, 0, 0, 0, 0, 0);
    chk(c_rd == 8'hCC && sp_o == 8'h7F, "R9 pop from upper", c_rd, 8'hCC);
    op(M_DIR, 8'h81, 0, 0, 1, 8'h07, 0);
  endtask

  task automatic t_no_upper;
    op(M_IND, 8'hF1, 0, 0, 1, 8'h9E, 0);
    op(M_IND, 8'hF1, 0, 0, 0, 0, 0);
    chk(c_rd_nu == 8'h00, "R10 write discarded", c_rd_nu, 8'h00);
    chk(c_rd == 8'h9E, "R10 reference instance keeps", c_rd, 8'h9E);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    #(CLK_PERIOD);
    t_reset();
    t_lower();
    t_split();
    t_sp_reg();
    t_bank();
    t_bit_low();
    t_bit_sfr();
    t_stack();
    t_no_upper();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule